// File: doc/BRIEF.md
# Idle-Time Dirty Row Scrubber

A background cleaning engine that sits beside a write-back cache. It steps a row pointer through the cache array, one row per cycle, and looks at each row's dirty flag through a plain index/read port: the cache returns the flag, tag and data of the row that `scan_idx_o` selects, in the same cycle. When it finds a dirty row and the main-memory port has no demand traffic, it latches that row and raises a single-row write request to memory. The request is held until memory accepts it.

In the cycle that memory accepts the write, the scrubber pulses a clean strobe with the row index, and the cache clears that row's dirty flag. If the CPU writes the same row after the scrubber latched it, the memory copy is already stale. In that case no clean strobe is issued, and the row is picked up again on a later pass. Demand requests always win over new scrub writes. An enable input stops new scan work. Eviction write-back stays with the cache controller.

Top module: `scrub_dirty_rows`

## Requirements
- R1: While `rst_ni` is low, `mem_req_o`, `busy_o` and `clean_o` are low and `scan_idx_o` is 0.
- R2: When enabled, with no demand and no write outstanding, the pointer examines one row per cycle in ascending order and wraps from row ROWS-1 to row 0. Dirty rows are written back in that order.
- R3: A write request carries the row index in the low IDX_W bits of `mem_addr_o`, with the row tag above it, and the row data as sampled when the row was latched. In a pass over a fixed set of dirty rows, each dirty row is written exactly once and no clean row is written.
- R4: `clean_o` is high only in a cycle where `mem_req_o` and `mem_ack_i` are both high. `clean_idx_o` then equals the written row's index.
- R5: In a cycle where `demand_req_i` is high and no write is outstanding, no request is started and the pointer holds.
- R6: Once raised, `mem_req_o` stays high with stable address and data until `mem_ack_i` is seen, whatever `demand_req_i` and `enable_i` do.
- R7: In a cycle where `enable_i` is low and no write is outstanding, no request is started and the pointer holds.
- R8: A CPU write (`cpu_wr_i` with `cpu_wr_idx_i`) to the latched row, at any time from the latch cycle through the handshake cycle, suppresses `clean_o` for that write. The row is written again on a later pass with its new data.
- R9: `busy_o` is high exactly while a write request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new scan steps and write starts |
| demand_req_i | input | 1 | Demand traffic is using the memory port |
| scan_idx_o | output | IDX_W | Row index presented to the cache read port |
| row_dirty_i | input | 1 | Dirty flag of the selected row |
| row_tag_i | input | TAG_W | Tag of the selected row |
| row_data_i | input | DATA_W | Data of the selected row |
| cpu_wr_i | input | 1 | CPU write into the cache this cycle |
| cpu_wr_idx_i | input | IDX_W | Row targeted by the CPU write |
| clean_o | output | 1 | Clear the dirty flag of `clean_idx_o` |
| clean_idx_o | output | IDX_W | Row to mark clean |
| mem_req_o | output | 1 | Write request to main memory |
| mem_ack_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | TAG_W+IDX_W | Row address {tag, index} |
| mem_data_o | output | DATA_W | Row data |
| busy_o | output | 1 | A write-back is outstanding |

## Verification
The bench uses the default 8 rows, a 4-bit tag and 16-bit data. With 8 rows, all 256 dirty-row patterns can be drained one after another, each with a memory accept latency of 0 to 3 cycles. For every pattern, the bench checks the write order from wherever the pointer happens to stand, the address and data of each write, and that every dirty row is written exactly once. Directed runs cover the pointer wrap, demand priority before and during a write, the enable gate, and a CPU write that lands while a write-back is in flight.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic {
    ST_SCAN  = 1'b0,
    ST_WRITE = 1'b1
  } scrub_state_e;
endpackage

// File: rtl/scrub_scan_ptr.sv
module scrub_scan_ptr #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROWS - 1);

  logic [IDX_W-1:0] idx_q, idx_nxt;

  generate
    if ((1 << IDX_W) == ROWS) begin : g_pow2
      assign idx_nxt = idx_q + 1'b1;
    end else begin : g_wrap
      assign idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (advance_i) idx_q <= idx_nxt;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/scrub_redirty.sv
// Tracks CPU writes to the row being written back.
module scrub_redirty #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             release_i,
  input  logic [IDX_W-1:0] row_idx_i,
  input  logic             cpu_wr_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  output logic             stale_o
);
  logic live_q, stale_q, hit;

  assign hit = cpu_wr_i && (cpu_idx_i == row_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (capture_i) begin
      live_q  <= 1'b1;
      stale_q <= hit;
    end else if (release_i) begin
      live_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (live_q && hit) begin
      stale_q <= 1'b1;
    end
  end

  assign stale_o = live_q && (stale_q || hit);
endmodule

// File: rtl/scrub_wb_port.sv
module scrub_wb_port #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      req_q  <= 1'b1;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign done_o = req_q && ack_i;
endmodule

// File: rtl/scrub_dirty_rows.sv
module scrub_dirty_rows
  import scrub_pkg::*;
#(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              demand_req_i,
  output logic [IDX_W-1:0]  scan_idx_o,
  input  logic              row_dirty_i,
  input  logic [TAG_W-1:0]  row_tag_i,
  input  logic [DATA_W-1:0] row_data_i,
  input  logic              cpu_wr_i,
  input  logic [IDX_W-1:0]  cpu_wr_idx_i,
  output logic              clean_o,
  output logic [IDX_W-1:0]  clean_idx_o,
  output logic              mem_req_o,
  input  logic              mem_ack_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              busy_o
);
  scrub_state_e state_q, state_d;
  logic go, scanning, capture, step, done, stale;
  logic [IDX_W-1:0] idx;

  assign go       = enable_i && !demand_req_i;
  assign scanning = (state_q == ST_SCAN);
  assign capture  = scanning && go && row_dirty_i;
  // pointer freezes while a write is outstanding
  assign step     = (scanning && go && !row_dirty_i) || done;

  always_comb begin
    state_d = state_q;
    if (capture)   state_d = ST_WRITE;
    else if (done) state_d = ST_SCAN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SCAN;
    else         state_q <= state_d;
  end

  scrub_scan_ptr #(.ROWS(ROWS), .IDX_W(IDX_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .advance_i(step),
    .idx_o    (idx)
  );

  scrub_redirty #(.IDX_W(IDX_W)) u_redirty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .release_i(done),
    .row_idx_i(idx),
    .cpu_wr_i (cpu_wr_i),
    .cpu_idx_i(cpu_wr_idx_i),
    .stale_o  (stale)
  );

  scrub_wb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(capture),
    .addr_i({row_tag_i, idx}),
    .data_i(row_data_i),
    .ack_i (mem_ack_i),
    .req_o (mem_req_o),
    .addr_o(mem_addr_o),
    .data_o(mem_data_o),
    .done_o(done)
  );

  assign scan_idx_o  = idx;
  assign clean_o     = done && !stale;
  assign clean_idx_o = idx;
  assign busy_o      = mem_req_o;
endmodule

// File: rtl/scrub_dirty_rows_chk.sv
module scrub_dirty_rows_chk #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              demand_req_i,
  input logic [IDX_W-1:0]  scan_idx_o,
  input logic              cpu_wr_i,
  input logic [IDX_W-1:0]  cpu_wr_idx_i,
  input logic              clean_o,
  input logic [IDX_W-1:0]  clean_idx_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !mem_req_o && !clean_o && scan_idx_o == '0);

  p_ptr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(scan_idx_o));

  p_clean_in_handshake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_o |-> mem_req_o && mem_ack_i && clean_idx_o == mem_addr_o[IDX_W-1:0]);

  p_demand_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && demand_req_i |=> !mem_req_o && $stable(scan_idx_o));

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));

  p_enable_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && !enable_i |=> !mem_req_o && $stable(scan_idx_o));

  p_redirty_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && cpu_wr_i && cpu_wr_idx_i == clean_idx_o |-> !clean_o);
endmodule

bind scrub_dirty_rows scrub_dirty_rows_chk #(
  .IDX_W (IDX_W),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_scrub_dirty_rows.sv
`timescale 1ns/1ps
module tb_scrub_dirty_rows;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int TW = 4;
  localparam int DW = 16;
  localparam int AW = TW + IW;
  localparam int LOGN = 4096;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic enable_i, demand_req_i;
  logic [IW-1:0] scan_idx_o;
  logic row_dirty_i;
  logic [TW-1:0] row_tag_i;
  logic [DW-1:0] row_data_i;
  logic cpu_wr_i;
  logic [IW-1:0] cpu_wr_idx_i;
  logic [DW-1:0] cpu_data;
  logic clean_o;
  logic [IW-1:0] clean_idx_o;
  logic mem_req_o, mem_ack_i;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;
  logic busy_o;

  always #10 clk_i = ~clk_i;

  scrub_dirty_rows dut (
    .clk_i, .rst_ni, .enable_i, .demand_req_i, .scan_idx_o,
    .row_dirty_i, .row_tag_i, .row_data_i, .cpu_wr_i, .cpu_wr_idx_i,
    .clean_o, .clean_idx_o, .mem_req_o, .mem_ack_i, .mem_addr_o,
    .mem_data_o, .busy_o
  );

  // cache array model
  logic          dirty_m [N];
  logic [TW-1:0] tag_m   [N];
  logic [DW-1:0] data_m  [N];
  logic          preload;
  logic [N-1:0]  pre_mask;
  int            pre_seed;
  int            clean_cnt = 0;

  function automatic logic [TW-1:0] exp_tag(int seed, int r);
    return TW'(r * 3 + seed);
  endfunction
  function automatic logic [DW-1:0] exp_data(int seed, int r);
    return DW'(seed * 37 + r * 1013 + 5);
  endfunction

  always @(posedge clk_i) begin
    if (preload) begin
      for (int r = 0; r < N; r++) begin
        dirty_m[r] <= pre_mask[r];
        tag_m[r]   <= exp_tag(pre_seed, r);
        data_m[r]  <= exp_data(pre_seed, r);
      end
    end else begin
      if (clean_o) begin
        dirty_m[clean_idx_o] <= 1'b0;
        clean_cnt <= clean_cnt + 1;
      end
      if (cpu_wr_i) begin
        dirty_m[cpu_wr_idx_i] <= 1'b1;
        data_m[cpu_wr_idx_i]  <= cpu_data;
      end
    end
  end

  assign row_dirty_i = dirty_m[scan_idx_o];
  assign row_tag_i   = tag_m[scan_idx_o];
  assign row_data_i  = data_m[scan_idx_o];

  // memory responder: ack after lat waiting cycles, log each accepted write
  int            lat = 0;
  int            wait_cnt = 0;
  int            wr_total = 0;
  logic [AW-1:0] log_addr [LOGN];
  logic [DW-1:0] log_data [LOGN];

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        mem_ack_i = 1'b1;
        wait_cnt  = 0;
        if (wr_total < LOGN) begin
          log_addr[wr_total] = mem_addr_o;
          log_data[wr_total] = mem_data_o;
        end
        wr_total = wr_total + 1;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  int n_checks = 0;
  int n_err    = 0;
  int log_rd   = 0;
  int busy_bad = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_rows(input logic [N-1:0] m, input int seed, output int start);
    @(negedge clk_i);
    preload = 1'b1; pre_mask = m; pre_seed = seed;
    @(negedge clk_i);
    preload = 1'b0;
    start = int'(scan_idx_o);
  endtask

  function automatic bit all_clean();
    for (int r = 0; r < N; r++) if (dirty_m[r]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain(input string req);
    int k;
    busy_bad = 0;
    k = 0;
    while (!(all_clean() && !mem_req_o) && k < 400) begin
      @(negedge clk_i);
      if (busy_o !== mem_req_o) busy_bad++;
      k++;
    end
    chk(k < 400, req, "drain finished within bound", k, 400);
  endtask

  task automatic sweep_one(input int m);
    int start, ptr, e, idx, exp_idx, c0, base;
    bit [N-1:0] done_rows;
    int cnt [N];
    lat = m % 4;
    c0 = clean_cnt;
    base = wr_total;
    load_rows(N'(m), m, start);
    drain("R3");
    ptr = start;
    done_rows = '0;
    for (int r = 0; r < N; r++) cnt[r] = 0;
    for (e = base; e < wr_total; e++) begin
      idx = int'(log_addr[e][IW-1:0]);
      exp_idx = -1;
      for (int k = 0; k < N; k++) begin
        int c = (ptr + k) % N;
        if (exp_idx < 0 && m[c] && !done_rows[c]) exp_idx = c;
      end
      chk(idx == exp_idx, "R2", "write order", idx, exp_idx);
      chk(log_addr[e][AW-1:IW] == exp_tag(m, idx), "R3", "tag field",
          log_addr[e][AW-1:IW], exp_tag(m, idx));
      chk(log_data[e] == exp_data(m, idx), "R3", "write data", log_data[e], exp_data(m, idx));
      cnt[idx]++;
      done_rows[idx] = 1'b1;
      ptr = (idx + 1) % N;
    end
    for (int r = 0; r < N; r++)
      chk(cnt[r] == (m[r] ? 1 : 0), "R3", $sformatf("writes to row %0d", r), cnt[r], m[r] ? 1 : 0);
    chk(clean_cnt - c0 == $countones(m), "R4", "clean strobes", clean_cnt - c0, $countones(m));
    chk(busy_bad == 0, "R9", "busy follows outstanding write", busy_bad, 0);
    log_rd = wr_total;
  endtask

  task automatic wait_req(input string req);
    int k = 0;
    while (!mem_req_o && k < 100) begin @(negedge clk_i); k++; end
    chk(mem_req_o, req, "request raised", mem_req_o, 1);
  endtask

  task automatic wait_req_low(input string req);
    int k = 0;
    while (mem_req_o && k < 100) begin @(negedge clk_i); k++; end
    chk(!mem_req_o, req, "request retired", mem_req_o, 0);
  endtask

  task automatic main_seq();
    int start, seen;
    logic [IW-1:0] idx0;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;

    rst_ni = 1'b0; enable_i = 1'b1; demand_req_i = 1'b0;
    preload = 1'b0; pre_mask = '0; pre_seed = 0;
    cpu_wr_i = 1'b0; cpu_wr_idx_i = '0; cpu_data = '0;
    @(negedge clk_i);
    preload = 1'b1;
    repeat (3) @(negedge clk_i);
    preload = 1'b0;
    // R1 reset state
    chk(!mem_req_o, "R1", "req in reset", mem_req_o, 0);
    chk(!busy_o, "R1", "busy in reset", busy_o, 0);
    chk(!clean_o, "R1", "clean in reset", clean_o, 0);
    chk(scan_idx_o == 0, "R1", "pointer in reset", scan_idx_o, 0);
    rst_ni = 1'b1;

    // R2 pointer walks one row per cycle and wraps
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_i);
      chk(int'(scan_idx_o) == k % N, "R2", "pointer step/wrap", scan_idx_o, k % N);
    end

    // exhaustive dirty patterns
    for (int m = 0; m < (1 << N); m++) sweep_one(m);

    // R5 demand priority before and during a write
    demand_req_i = 1'b1;
    lat = 10;
    load_rows('1, 7, start);
    idx0 = scan_idx_o;
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (mem_req_o || scan_idx_o != idx0) seen++;
    end
    chk(seen == 0, "R5", "cycles with start or pointer move under demand", seen, 0);
    demand_req_i = 1'b0;
    wait_req("R5");
    demand_req_i = 1'b1;
    a0 = mem_addr_o; d0 = mem_data_o;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (!mem_req_o || mem_addr_o != a0 || mem_data_o != d0) seen++;
    end
    chk(seen == 0, "R6", "request held under demand", seen, 0);
    wait_req_low("R6");
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (mem_req_o) seen++;
    end
    chk(seen == 0, "R5", "no new start after write under demand", seen, 0);
    demand_req_i = 1'b0;
    lat = 1;
    drain("R5");

    // R7 enable gate
    enable_i = 1'b0;
    load_rows('1, 21, start);
    idx0 = scan_idx_o;
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (mem_req_o || scan_idx_o != idx0) seen++;
    end
    chk(seen == 0, "R7", "cycles with start or pointer move while disabled", seen, 0);
    lat = 6;
    enable_i = 1'b1;
    wait_req("R7");
    enable_i = 1'b0;
    a0 = mem_addr_o;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      if (!mem_req_o || mem_addr_o != a0) seen++;
    end
    chk(seen == 0, "R6", "request held while disabled", seen, 0);
    wait_req_low("R7");
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (mem_req_o) seen++;
    end
    chk(seen == 0, "R7", "no new start while disabled", seen, 0);
    enable_i = 1'b1;
    lat = 0;
    drain("R7");

    // R8 CPU write lands while the row is in flight
    lat = 8;
    start = clean_cnt;
    load_rows(8'h20, 99, seen);
    wait_req("R8");
    chk(mem_addr_o[IW-1:0] == 3'd5, "R8", "row in flight", mem_addr_o[IW-1:0], 5);
    chk(mem_data_o == exp_data(99, 5), "R8", "first write data", mem_data_o, exp_data(99, 5));
    @(negedge clk_i);
    cpu_wr_i = 1'b1; cpu_wr_idx_i = 3'd5; cpu_data = 16'hBEEF;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    wait_req_low("R8");
    @(negedge clk_i);
    chk(dirty_m[5] == 1'b1, "R8", "row still dirty after stale write", dirty_m[5], 1);
    chk(clean_cnt == start, "R8", "no clean strobe for stale write", clean_cnt - start, 0);
    wait_req("R8");
    chk(mem_data_o == 16'hBEEF, "R8", "second write data", mem_data_o, 16'hBEEF);
    drain("R8");
    chk(dirty_m[5] == 1'b0, "R8", "row clean after second write", dirty_m[5], 0);
    chk(clean_cnt - start == 1, "R4", "one clean strobe after rewrite", clean_cnt - start, 1);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk_i);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "R2", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule